// File: doc/BRIEF.md
# Glitch-Free Divide-by-Five Clock Generator

This block takes an input clock and produces a clock at one fifth of its frequency. The output is high for exactly two and a half input periods and low for two and a half. A three-bit phase counter runs on the rising edge and cycles through five states. One register clocked on the falling edge delays a single counter bit by half an input period. The output is the OR of that counter bit and its delayed copy.

Both inputs of the output gate come straight from flip-flops, and no decode of several counter bits takes part. The output therefore changes only when one of those two flops changes, and it cannot glitch. The block needs no reset. From any power-up state it falls into the correct waveform within two output periods. An optional synchronous reset puts it into a known phase.

Top module: `odd_clk_div5`

## Requirements
- R1: The phase counter steps 0,1,2,3,4 and then back to 0 on successive rising input edges, so the output repeats every five input periods.
- R2: In steady operation every output high pulse and every output low pulse lasts exactly 2.5 input periods (five half-periods each).
- R3: The output rises only just after a rising input edge, when the counter enters state 2. It falls only just after a falling input edge, during state 4.
- R4: The output changes at most once in any input half-period.
- R5: A counter value of 5, 6 or 7 becomes 0 at the next rising edge. For such a start, the output is low after the second rising edge and rises at the third.
- R6: With no reset, the output locks to the R2 waveform from any of the eight counter values. The first clean rising edge of the output comes no later than the tenth rising input edge.
- R7: While the reset is high, the counter is held at 0 and the falling-edge register clears on each falling edge, so the output is low after the first rising edge under reset. After the reset is released, the output stays low through the first rising edge and rises at the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst | input | 1 | Optional active-high synchronous reset |
| clk_out | output | 1 | Divided clock, input frequency / 5, 50% duty |

## Verification
Eight copies of the block start with the counter loaded to each of the eight possible values and no reset. This covers the five legal phases, each of which locks with a different latency, and the three unused values, which must fall straight back to 0. A behavioural half-period model syncs to each copy's first clean rising edge and then predicts the output at every input edge, so a wrong duty, a wrong period or an edge on the wrong input phase each produce a mismatch. A toggle counter on each output catches any extra transition inside a half-period. A final reset pass confirms the known start phase.

// File: rtl/div5_pkg.sv
`timescale 1ns/1ps
package div5_pkg;

    // Division ratio; odd, so a half-period extension is needed for 50% duty.
    localparam int unsigned DIV_RATIO = 5;
    localparam int unsigned CNT_W     = $clog2(DIV_RATIO);
    localparam int unsigned LAST_PH   = DIV_RATIO - 1;
    // Counter bit that is high for two consecutive phases (2 and 3).
    localparam int unsigned TAP_BIT   = 1;

    typedef logic [CNT_W-1:0] phase_t;

    // The two register-sourced inputs of the output gate.
    typedef struct packed {
        logic tap;  // counter bit, rising-edge domain
        logic ext;  // same bit delayed half a period
    } clk_parts_t;

    // Next counter value; any value at or past the last phase returns to 0,
    // so unused encodings cannot trap the counter.
    function automatic phase_t next_phase(input phase_t cur);
        if (cur >= phase_t'(LAST_PH))
            return '0;
        else
            return cur + phase_t'(1);
    endfunction

    function automatic logic combine(input clk_parts_t p);
        return p.tap | p.ext;
    endfunction

endpackage

// File: rtl/div5_phase_counter.sv
`timescale 1ns/1ps
module div5_phase_counter
    import div5_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_t phase_q,
    output logic   tap
);

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else
            phase_q <= next_phase(phase_q);
    end

    assign tap = phase_q[TAP_BIT];

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (phase_q == phase_t'(LAST_PH)) |=> (phase_q == '0)); // R1

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        (phase_q < phase_t'(LAST_PH)) |=> (phase_q == phase_t'($past(phase_q) + phase_t'(1)))); // R1

    AST_UNUSED_EXIT: assert property (@(posedge clk) disable iff (rst)
        (phase_q > phase_t'(LAST_PH)) |=> (phase_q == '0)); // R5

    AST_RESET_HOLD: assert property (@(posedge clk)
        rst |=> (phase_q == '0)); // R7

endmodule

// File: rtl/div5_half_ext.sv
`timescale 1ns/1ps
module div5_half_ext (
    input  logic clk,
    input  logic rst,
    input  logic tap_in,
    output logic ext_q
);

    // Falling-edge copy of the tap: stretches the high time by half a period.
    always_ff @(negedge clk) begin
        if (rst)
            ext_q <= 1'b0;
        else
            ext_q <= tap_in;
    end

endmodule

// File: rtl/odd_clk_div5.sv
`timescale 1ns/1ps
module odd_clk_div5
    import div5_pkg::*;
(
    input  logic clk_in,
    input  logic rst,
    output logic clk_out
);

    phase_t     phase_w;
    logic       tap_w;
    logic       ext_w;
    clk_parts_t parts;

    div5_phase_counter u_cnt (
        .clk     (clk_in),
        .rst     (rst),
        .phase_q (phase_w),
        .tap     (tap_w)
    );

    div5_half_ext u_ext (
        .clk    (clk_in),
        .rst    (rst),
        .tap_in (tap_w),
        .ext_q  (ext_w)
    );

    assign parts   = '{tap: tap_w, ext: ext_w};
    // Both gate inputs are flop outputs: no decode reaches the output.
    assign clk_out = combine(parts);

    // Half-period register seen high by the end of phase 3 after a normal step.
    AST_EXT_HIGH_LATE: assert property (@(posedge clk_in) disable iff (rst)
        ((phase_w == phase_t'(3)) && ($past(phase_w) == phase_t'(2))) |-> ext_w); // R2

    // And low by the end of phase 1 after a normal step.
    AST_EXT_LOW_EARLY: assert property (@(posedge clk_in) disable iff (rst)
        ((phase_w == phase_t'(1)) && ($past(phase_w) == phase_t'(0))) |-> !ext_w); // R3

endmodule

// File: tb/odd_clk_div5_test.sv
`timescale 1ns/1ps
module odd_clk_div5_test;

    localparam int N_INST  = 8;
    localparam int RUN_CYC = 40;

    logic clk = 1'b0;
    logic rst = 1'b0;
    logic clk_out_w [N_INST];
    int   tgl       [N_INST];
    logic prev_v    [N_INST];
    bit   synced    [N_INST];
    int   ph        [N_INST];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    always #5 clk = ~clk;

    for (genvar g = 0; g < N_INST; g++) begin : g_inst
        localparam logic [2:0] START = 3'(g);
        odd_clk_div5 uut (
            .clk_in  (clk),
            .rst     (rst),
            .clk_out (clk_out_w[g])
        );
        // Load the power-up state directly; no reset is used.
        initial begin
            uut.u_cnt.phase_q = START;
            uut.u_ext.ext_q   = START[1];
        end
        always @(clk_out_w[g]) tgl[g] = tgl[g] + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    task automatic sample(input bit is_pos, input int cyc);
        for (int i = 0; i < N_INST; i++) begin
            logic cur;
            cur = clk_out_w[i];
            check(tgl[i] <= 1, "R4 toggles per half-period", tgl[i], 1);
            tgl[i] = 0;
            if (is_pos && i >= 5 && cyc == 2) check(cur == 1'b0, "R5 low after 2nd edge", int'(cur), 0);
            if (is_pos && i >= 5 && cyc == 3) check(cur == 1'b1, "R5 rise at 3rd edge", int'(cur), 1);
            if (!synced[i]) begin
                if (!is_pos && prev_v[i] == 1'b0 && cur == 1'b1)
                    check(1'b0, "R3 rise on falling edge", 1, 0);
                if (is_pos && prev_v[i] == 1'b0 && cur == 1'b1) begin
                    synced[i] = 1'b1;
                    ph[i] = 0;
                    check(cyc <= 10, "R6 lock latency", cyc, 10);
                end
            end else begin
                ph[i] = (ph[i] + 1) % 10;
                // R1/R2/R3: high for half-periods 0..4 from the rise, low for 5..9
                check(cur == (ph[i] < 5), "R2 waveform", int'(cur), int'(ph[i] < 5));
            end
            prev_v[i] = cur;
        end
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #1;
        for (int i = 0; i < N_INST; i++) begin
            tgl[i] = 0;
            prev_v[i] = clk_out_w[i];
            synced[i] = 1'b0;
            ph[i] = 0;
        end
        for (int cyc = 1; cyc <= RUN_CYC; cyc++) begin
            @(posedge clk); #2;
            sample(1'b1, cyc);
            @(negedge clk); #2;
            sample(1'b0, cyc);
        end
        for (int i = 0; i < N_INST; i++)
            check(synced[i], "R6 locked from every start", int'(synced[i]), 1);

        // Reset pass
        @(posedge clk); #1;
        rst = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #2;
            for (int i = 0; i < N_INST; i++)
                check(clk_out_w[i] == 1'b0, "R7 low under reset (rise)", int'(clk_out_w[i]), 0);
            @(negedge clk); #2;
            for (int i = 0; i < N_INST; i++)
                check(clk_out_w[i] == 1'b0, "R7 low under reset (fall)", int'(clk_out_w[i]), 0);
        end
        @(posedge clk); #1;
        rst = 1'b0;
        @(posedge clk); #2;
        for (int i = 0; i < N_INST; i++)
            check(clk_out_w[i] == 1'b0, "R7 low at first edge after release", int'(clk_out_w[i]), 0);
        @(negedge clk); #2;
        for (int i = 0; i < N_INST; i++)
            check(clk_out_w[i] == 1'b0, "R7 low between edges", int'(clk_out_w[i]), 0);
        @(posedge clk); #2;
        for (int i = 0; i < N_INST; i++)
            check(clk_out_w[i] == 1'b1, "R7 rise at second edge", int'(clk_out_w[i]), 1);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule